// File: doc/BRIEF.md
# Three-lane forwarded-clock character deserializer

This block takes three serial data lanes (lane 0 red, lane 1 green, lane 2 blue) and turns each one into a stream of 10-bit characters. All three lanes come from one transmitter, which also forwards a character clock. Each lane presents one sampled data bit per bit-clock cycle, together with its own sampled level of that character clock. When that level goes from high to low, a new character starts.

Each lane may arrive a few bit times late relative to the others. A small queue per lane absorbs this skew. During blanking, the transmitter repeats a fixed synchronization character. The block uses it to line the lanes up, so that the three words it presents together always come from the same character slot.

The block first acquires alignment from the sync characters. After that, it keeps checking the alignment every time sync characters reach the heads of the queues. It drops its locked flag when the lanes disagree, and acquires alignment again at the next consistent blanking run. Decoding the characters to 8-bit data and removing fill characters are left to later stages.

Top module: `tri_lane_deser`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `locked` and `char_valid` are 0. With idle inputs (data 0, character clock high), `locked` stays 0.
- R2: Bits within a character are taken least significant first: the first bit of a character becomes bit 0 of the output word. The sync character is 10'b1101010100 (0x354).
- R3: On each lane, a character boundary is set by a high-to-low change of that lane's sampled character clock level. The data bit sampled in the cycle where the level is first low is bit 0. Framing is tracked separately per lane.
- R4: With lane skews of up to 13 bit times, the three output fields always carry characters of the same transmitted slot, in transmit order, with none lost or repeated.
- R5: While unlocked, a lane discards characters until it receives a sync character. Lock is taken when all three queue heads hold the sync character, and the first word after lock shows the sync character on every lane.
- R6: `char_valid` is 1 only while `locked` is 1, and marks one aligned word per character slot.
- R7: While locked, if some but not all queue heads hold the sync character, `locked` drops, no word is emitted for that slot, and all queues are emptied.
- R8: After losing lock, the block acquires lock again at the next blanking run in which all lanes carry the sync character in the same slots. Data after that run is aligned again.
- R9: A character arriving at a lane whose queue is full empties all queues and drops lock. Stale sync characters therefore cannot cause a later false alignment.
- R10: A word emitted with `char_valid` never shows the sync character on only some of the lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one sample per lane per cycle |
| rst | input | 1 | Synchronous active-high reset |
| rx_bit | input | 3 | Sampled serial data bit, one per lane (bit 0 red, 1 green, 2 blue) |
| rx_cclk | input | 3 | Sampled character clock level seen by each lane |
| char_out | output | 30 | Aligned characters, lane n in bits [10n+9:10n] |
| char_valid | output | 1 | An aligned word is present on char_out this cycle |
| locked | output | 1 | Lanes are aligned |

## Verification
A lane that frames characters at the wrong place shows up on `char_out` as shifted bit patterns. It can also show up as a failure to lock at all, since the sync character is never recognised. Either symptom appears within the first blanking run.

A queue that keeps stale entries, or a comparison that accepts mixed sync heads, shows up as output fields from different character slots. This is visible on the first word after the next lock, and again each time sync characters pass through.

A lock state that fails to clear or to set is visible on `locked` one cycle after the deciding slot reaches the queue heads.

// File: rtl/deser_pkg.sv
package deser_pkg;
   parameter int unsigned DFLT_LANES  = 3;
   parameter int unsigned DFLT_CHAR_W = 10;
   parameter int unsigned DFLT_DEPTH  = 4;
   parameter logic [9:0]  DFLT_SYNC   = 10'b1101010100;

   typedef enum logic {
      ST_HUNT  = 1'b0,
      ST_TRACK = 1'b1
   } align_st_e;
endpackage

// File: rtl/char_framer.sv
module char_framer #(
   parameter int unsigned CW = 10
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          ser_bit,
   input  logic          cclk_lvl,
   output logic          word_vld,
   output logic [CW-1:0] word
);
   localparam int unsigned CNT_W = $clog2(CW);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(CW - 1);

   logic [CW-1:0]    shreg;
   logic [CNT_W-1:0] bit_cnt;
   logic             cclk_q;
   logic             fall;

   assign fall = cclk_q & ~cclk_lvl;

   always_ff @(posedge clk) begin
      if (rst) begin
         shreg    <= '0;
         bit_cnt  <= '0;
         cclk_q   <= 1'b0;
         word_vld <= 1'b0;
         word     <= '0;
      end else begin
         cclk_q   <= cclk_lvl;
         shreg    <= {ser_bit, shreg[CW-1:1]};
         word_vld <= 1'b0;
         if (fall) begin
            bit_cnt <= CNT_W'(1);
         end else if (bit_cnt == LAST) begin
            bit_cnt  <= '0;
            word_vld <= 1'b1;
            word     <= {ser_bit, shreg[CW-1:1]};
         end else begin
            bit_cnt <= bit_cnt + CNT_W'(1);
         end
      end
   end
endmodule

// File: rtl/char_fifo.sv
module char_fifo #(
   parameter int unsigned W     = 10,
   parameter int unsigned DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         flush,
   input  logic         push,
   input  logic         pop,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] rdata,
   output logic         empty,
   output logic         full
);
   localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CNTW = $clog2(DEPTH + 1);

   logic [W-1:0]    mem [DEPTH];
   logic [PW-1:0]   wp, rp;
   logic [CNTW-1:0] cnt;

   function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
      return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
   endfunction

   always_ff @(posedge clk) begin
      if (rst || flush) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (push) wp <= nxt(wp);
         if (pop)  rp <= nxt(rp);
         cnt <= cnt + CNTW'(push) - CNTW'(pop);
      end
   end

   always_ff @(posedge clk) begin
      if (push && !rst && !flush) mem[wp] <= wdata;
   end

   assign rdata = mem[rp];
   assign empty = (cnt == '0);
   assign full  = (cnt == CNTW'(DEPTH));
endmodule

// File: rtl/lane_align_ctrl.sv
module lane_align_ctrl
   import deser_pkg::*;
#(
   parameter int unsigned LANES = 3,
   parameter int unsigned CW    = 10,
   parameter logic [CW-1:0] SYNC = DFLT_SYNC
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [LANES-1:0]    in_vld,
   input  logic [LANES*CW-1:0] in_word,
   input  logic [LANES*CW-1:0] head,
   input  logic [LANES-1:0]    empty,
   input  logic [LANES-1:0]    full,
   output logic [LANES-1:0]    push,
   output logic                pop,
   output logic                flush,
   output logic [LANES*CW-1:0] out_word,
   output logic                out_vld,
   output logic                locked
);
   align_st_e        st;
   logic [LANES-1:0] want, hit;
   logic             all_ready, mismatch, overflow, take;

   always_comb begin
      for (int l = 0; l < LANES; l++) begin
         hit[l]  = (head[l*CW +: CW] == SYNC);
         want[l] = in_vld[l] &&
                   ((st == ST_TRACK) || !empty[l] || (in_word[l*CW +: CW] == SYNC));
      end
   end

   assign all_ready = ~|empty;
   assign mismatch  = all_ready && (|hit) && !(&hit);
   assign overflow  = |(want & full);
   assign flush     = overflow || mismatch;
   assign take      = all_ready && ((st == ST_TRACK) ? 1'b1 : (&hit));
   assign pop       = take && !flush;
   assign push      = flush ? '0 : want;
   assign locked    = (st == ST_TRACK);

   always_ff @(posedge clk) begin
      if (rst) begin
         st       <= ST_HUNT;
         out_vld  <= 1'b0;
         out_word <= '0;
      end else if (flush) begin
         st      <= ST_HUNT;
         out_vld <= 1'b0;
      end else if (pop) begin
         st       <= ST_TRACK;
         out_vld  <= 1'b1;
         out_word <= head;
      end else begin
         out_vld <= 1'b0;
      end
   end
endmodule

// File: rtl/tri_lane_deser.sv
module tri_lane_deser
   import deser_pkg::*;
#(
   parameter int unsigned LANES = DFLT_LANES,
   parameter int unsigned CW    = DFLT_CHAR_W,
   parameter int unsigned DEPTH = DFLT_DEPTH,
   parameter logic [CW-1:0] SYNC = CW'(DFLT_SYNC)
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [LANES-1:0]    rx_bit,
   input  logic [LANES-1:0]    rx_cclk,
   output logic [LANES*CW-1:0] char_out,
   output logic                char_valid,
   output logic                locked
);
   localparam int unsigned BUS_W = LANES * CW;

   if (CW < 2) begin : g_bad_cw
      $fatal(1, "character width must be at least 2");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $fatal(1, "queue depth must be at least 2");
   end
   if (LANES < 1) begin : g_bad_lanes
      $fatal(1, "at least one lane is required");
   end

   logic [LANES-1:0] f_vld, q_push, q_empty, q_full;
   logic [BUS_W-1:0] f_word, q_head;
   logic             q_pop, q_flush;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      char_framer #(.CW(CW)) u_frm (
         .clk      (clk),
         .rst      (rst),
         .ser_bit  (rx_bit[l]),
         .cclk_lvl (rx_cclk[l]),
         .word_vld (f_vld[l]),
         .word     (f_word[l*CW +: CW])
      );
      char_fifo #(.W(CW), .DEPTH(DEPTH)) u_q (
         .clk   (clk),
         .rst   (rst),
         .flush (q_flush),
         .push  (q_push[l]),
         .pop   (q_pop),
         .wdata (f_word[l*CW +: CW]),
         .rdata (q_head[l*CW +: CW]),
         .empty (q_empty[l]),
         .full  (q_full[l])
      );
   end

   lane_align_ctrl #(.LANES(LANES), .CW(CW), .SYNC(SYNC)) u_ctl (
      .clk      (clk),
      .rst      (rst),
      .in_vld   (f_vld),
      .in_word  (f_word),
      .head     (q_head),
      .empty    (q_empty),
      .full     (q_full),
      .push     (q_push),
      .pop      (q_pop),
      .flush    (q_flush),
      .out_word (char_out),
      .out_vld  (char_valid),
      .locked   (locked)
   );
endmodule

// File: rtl/tri_lane_deser_chk.sv
module tri_lane_deser_chk #(
   parameter int unsigned LANES = 3,
   parameter int unsigned CW    = 10,
   parameter logic [CW-1:0] SYNC = '0
) (
   input logic                clk,
   input logic                rst,
   input logic [LANES*CW-1:0] char_out,
   input logic                char_valid,
   input logic                locked
);
   logic [LANES-1:0] shows_sync;

   always_comb begin
      for (int l = 0; l < LANES; l++)
         shows_sync[l] = (char_out[l*CW +: CW] == SYNC);
   end

   // R1: reset clears lock and output strobe
   a_r1_reset_clear: assert property (@(posedge clk)
      rst |=> (!locked && !char_valid));

   // R6: words only while locked
   a_r6_valid_when_locked: assert property (@(posedge clk) disable iff (rst)
      char_valid |-> locked);

   // R5: lock is taken on a sync word shown on all lanes
   a_r5_lock_on_sync: assert property (@(posedge clk) disable iff (rst)
      $rose(locked) |-> (char_valid && (&shows_sync)));

   // R10: never a partial sync word
   a_r10_no_partial_sync: assert property (@(posedge clk) disable iff (rst)
      (char_valid && (|shows_sync)) |-> (&shows_sync));

   // R7: a dropped lock emits nothing in that cycle
   a_r7_drop_silent: assert property (@(posedge clk) disable iff (rst)
      $fell(locked) |-> !char_valid);
endmodule

bind tri_lane_deser tri_lane_deser_chk #(
   .LANES (LANES),
   .CW    (CW),
   .SYNC  (SYNC)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .char_out   (char_out),
   .char_valid (char_valid),
   .locked     (locked)
);

// File: tb/sim_tri_lane_deser.sv
module sim_tri_lane_deser;
   localparam int CW = 10;
   localparam logic [9:0] SYNC = 10'b1101010100;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [2:0]  rx_bit = '0;
   logic [2:0]  rx_cclk = '1;
   logic [29:0] char_out;
   logic        char_valid, locked;

   always #10 clk = ~clk;

   tri_lane_deser u0 (
      .clk(clk), .rst(rst), .rx_bit(rx_bit), .rx_cclk(rx_cclk),
      .char_out(char_out), .char_valid(char_valid), .locked(locked)
   );

   logic [9:0] tx [3][64];
   logic [9:0] rx [3][256];
   int rx_n, lock_rises, lock_falls, unlocked_valid, mixed_cnt;
   int total = 0, fails = 0;
   logic prev_locked = 1'b0;

   always @(negedge clk) begin
      if (!rst) begin
         if (locked && !prev_locked) begin lock_rises++; rx_n = 0; end
         if (!locked && prev_locked) lock_falls++;
         if (char_valid) begin
            int h;
            h = 0;
            if (!locked) unlocked_valid++;
            for (int l = 0; l < 3; l++) begin
               if (char_out[l*CW +: CW] == SYNC) h++;
               if (rx_n < 256) rx[l][rx_n] = char_out[l*CW +: CW];
            end
            if (h != 0 && h != 3) mixed_cnt++;
            rx_n++;
         end
      end
      prev_locked = locked;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic logic [9:0] data_char(input int l, input int k);
      logic [9:0] d;
      d = 10'((k * 53 + l * 211 + 17) % 1024);
      if (d == SYNC) d = d ^ 10'd1;
      return d;
   endfunction

   // scen 0: one clean blank; 1: misaligned second blank; 2: partial first blank
   task automatic build(input int scen);
      for (int l = 0; l < 3; l++)
         for (int k = 0; k < 64; k++) begin
            bit s;
            s = 1'b0;
            if (scen == 0) s = (k >= 2 && k <= 7);
            if (scen == 1) s = (k >= 2 && k <= 7) || (k >= 35 && k <= 40) ||
                               ((l < 2) ? (k >= 20 && k <= 23) : (k >= 21 && k <= 24));
            if (scen == 2) s = ((l < 2) && k >= 2 && k <= 7) || (k >= 20 && k <= 25);
            tx[l][k] = s ? SYNC : data_char(l, k);
         end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; rx_bit = '0; rx_cclk = '1;
      repeat (3) @(negedge clk);
      rx_n = 0; lock_rises = 0; lock_falls = 0; unlocked_valid = 0; mixed_cnt = 0;
      rst = 1'b0;
   endtask

   task automatic drive(input int nch, input int d0, input int d1, input int d2);
      int d [3];
      d[0] = d0; d[1] = d1; d[2] = d2;
      for (int t = 0; t < nch * 10 + 60; t++) begin
         @(negedge clk);
         for (int l = 0; l < 3; l++) begin
            int p;
            p = t - d[l];
            if (p < 0 || p >= nch * 10) begin
               rx_bit[l] = 1'b0; rx_cclk[l] = 1'b1;
            end else begin
               rx_bit[l]  = tx[l][p / 10][p % 10];
               rx_cclk[l] = ((p % 10) >= 5);
            end
         end
      end
      repeat (20) @(negedge clk);
   endtask

   function automatic int stream_errs(input int start, input int cnt);
      int e;
      e = 0;
      for (int n = 0; n < cnt; n++)
         for (int l = 0; l < 3; l++)
            if (rx[l][n] !== tx[l][start + n]) e++;
      return e;
   endfunction

   task automatic t_reset();
      @(negedge clk);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      chk(locked == 1'b0, "R1", "locked in reset", int'(locked), 0);
      chk(char_valid == 1'b0, "R1", "valid in reset", int'(char_valid), 0);
      rst = 1'b0;
      repeat (40) @(negedge clk);
      chk(locked == 1'b0, "R1", "locked after idle", int'(locked), 0);
   endtask

   task automatic t_deskew(input int d0, input int d1, input int d2);
      do_reset();
      build(0);
      drive(40, d0, d1, d2);
      chk(locked == 1'b1, "R5", "locked after blank", int'(locked), 1);
      chk(lock_rises == 1, "R5", "lock acquisitions", lock_rises, 1);
      chk(rx[0][0] == SYNC && rx[1][0] == SYNC && rx[2][0] == SYNC,
          "R2", "first word lsb-first sync on lane 2", int'(rx[2][0]), int'(SYNC));
      chk(rx_n >= 36, "R4", "word count", rx_n, 36);
      chk(stream_errs(2, 36) == 0, "R3", "framing/deskew errors", stream_errs(2, 36), 0);
      chk(unlocked_valid == 0, "R6", "valid while unlocked", unlocked_valid, 0);
      chk(mixed_cnt == 0, "R10", "partial sync words", mixed_cnt, 0);
   endtask

   task automatic t_misalign();
      do_reset();
      build(1);
      drive(60, 0, 0, 0);
      chk(lock_falls >= 1, "R7", "lock drops on disagreement", lock_falls, 1);
      chk(lock_rises == 3, "R7", "lock acquisitions", lock_rises, 3);
      chk(locked == 1'b1, "R8", "relocked after clean blank", int'(locked), 1);
      chk(rx_n >= 23, "R8", "word count after relock", rx_n, 23);
      chk(stream_errs(35, 23) == 0, "R8", "data errors after relock", stream_errs(35, 23), 0);
      chk(mixed_cnt == 0, "R10", "partial sync words", mixed_cnt, 0);
      chk(unlocked_valid == 0, "R6", "valid while unlocked", unlocked_valid, 0);
   endtask

   task automatic t_overflow();
      do_reset();
      build(2);
      drive(50, 0, 4, 9);
      chk(lock_rises == 1, "R9", "single lock after full blank", lock_rises, 1);
      chk(rx_n >= 26, "R9", "word count", rx_n, 26);
      chk(stream_errs(20, 26) == 0, "R9", "stale-entry errors", stream_errs(20, 26), 0);
   endtask

   initial begin
      t_reset();
      t_deskew(0, 0, 0);
      t_deskew(0, 7, 13);
      t_deskew(13, 0, 5);
      t_misalign();
      t_overflow();
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      #(20 * 200000);
      total++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule